// File: doc/BRIEF.md
# Run-Length Frame Expander with Column-to-Page Transpose

The block rebuilds one monochrome display frame from a compressed image kept in read-only storage. A start pulse carries a frame number; the block looks up that frame's descriptor (where its records begin and how many bytes they take), walks the record stream and writes the expanded bytes into a 1024-byte framebuffer of 8 pages by 128 columns.

Each record is two bytes: a repeat count followed by the byte to repeat. The stream lists the image column by column, eight page bytes per column. The block keeps a (page, column) write cursor that moves down the eight pages of a column before it steps to the next column, so the output lands in the page-major layout the display memory uses. Malformed streams end the frame early with an error. Storage reads take one clock, and inside a run the block writes one byte per clock.

Top module: `rle_frame_expander`

## Requirements
- R1: When `start` is high on a clock edge while the block is idle, it reads the descriptor of the selected frame and then fetches record bytes from `tbl_offset` upward, consuming exactly `tbl_length` bytes.
- R2: Every record is a count byte (at the lower address) then a value byte; the value is written to the framebuffer as many times as the count says.
- R3: The write cursor starts each frame at page 0, column 0; after each write the page rises by one, and after page 7 it returns to page 0 and the column rises by one.
- R4: Each byte is written to framebuffer address page*128 + column; a frame whose runs add up to 1024 bytes writes every one of the 1024 addresses exactly once.
- R5: The descriptor read is issued the clock after start and its data used one clock later; each record costs two fetch clocks; the first write of a run appears on `fb_we` three clocks after the count byte is requested, and the run's writes follow on consecutive clocks.
- R6: An odd descriptor length, a count byte of zero, or a write cursor that has moved past column 127 ends the frame with no further writes, and `error` is high together with `done`.
- R7: The frame number used is `frame_idx` modulo the frame-count parameter, so an index past the last frame wraps to frame 0 onward.
- R8: `done` is high for exactly one clock, the clock after the frame's last write, and `busy` is low from that clock on.
- R9: A start pulse while `busy` is high is ignored and does not alter the frame in progress.
- R10: After reset `busy`, `done`, `error`, `fb_we`, `tbl_rd_en` and `mem_rd_en` are all low.
- R11: A frame of length zero finishes with `done`, no framebuffer writes and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin expanding a frame |
| frame_idx | input | IDX_W | Requested frame number (wrapped modulo FRAME_CNT) |
| busy | output | 1 | A frame is being expanded |
| done | output | 1 | One-clock pulse at the end of a frame |
| error | output | 1 | High with `done` when the frame was malformed |
| tbl_rd_en | output | 1 | Descriptor read request |
| tbl_rd_idx | output | FSEL_W | Descriptor number to read |
| tbl_offset | input | ADDR_W | Start address of the frame records, one clock after the request |
| tbl_length | input | LEN_W | Byte length of the frame records, one clock after the request |
| mem_rd_en | output | 1 | Record store read request |
| mem_rd_addr | output | ADDR_W | Record store byte address |
| mem_rd_data | input | 8 | Record store data, one clock after the request |
| fb_we | output | 1 | Framebuffer write strobe |
| fb_addr | output | FB_AW | Framebuffer byte address |
| fb_wdata | output | 8 | Framebuffer write data |

## Verification
On every clock the assertions check the local shape of the write stream: consecutive writes in a run carry the same byte and step the address by one page (or to the next column's page 0), writes and reads happen only while busy, `done` is a lone pulse with no write beside it, and `error` never appears without `done`. Whether the right bytes go to the right addresses in the right clocks, whether the index wraps correctly, whether each malformed stream is caught at the right point, and whether a start during a frame is really ignored can only be shown by the bench's frames compared against its cycle model.

// File: rtl/rle_pkg.sv
package rle_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for start
    ST_DESC,   // descriptor read issued
    ST_DLAT,   // descriptor data valid
    ST_CREQ,   // count byte read issued
    ST_VREQ,   // value byte read issued, count byte valid
    ST_RUN,    // expanding a run
    ST_FIN     // wrap-up, done next clock
  } rle_state_e;

endpackage

// File: rtl/rle_idx_wrap.sv
module rle_idx_wrap #(
  parameter int IDX_W     = 8,
  parameter int FRAME_CNT = 50,
  parameter int SEL_W     = 6
) (
  input  logic [IDX_W-1:0] idx,
  output logic [SEL_W-1:0] sel
);

  localparam bit IS_POW2 = (FRAME_CNT & (FRAME_CNT - 1)) == 0;

  generate
    if (IS_POW2) begin : g_mask
      // power-of-two frame count: wrapping is a bit slice
      assign sel = SEL_W'(idx);
    end else begin : g_mod
      assign sel = SEL_W'(int'(idx) % FRAME_CNT);
    end
  endgenerate

endmodule

// File: rtl/rle_cursor.sv
module rle_cursor #(
  parameter int PAGES = 8,
  parameter int COLS  = 128,
  parameter int FB_AW = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  output logic [FB_AW-1:0] addr,
  output logic             past_end
);

  localparam int PW = (PAGES > 1) ? $clog2(PAGES) : 1;
  localparam int CW = $clog2(COLS) + 1;

  logic [PW-1:0] page_q;
  logic [CW-1:0] col_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      page_q <= '0;
      col_q  <= '0;
    end else if (step) begin
      if (page_q == PW'(PAGES - 1)) begin
        page_q <= '0;
        col_q  <= col_q + CW'(1);
      end else begin
        page_q <= page_q + PW'(1);
      end
    end
  end

  // page-major byte address of the cursor
  assign addr     = FB_AW'(page_q) * FB_AW'(COLS) + FB_AW'(col_q);
  assign past_end = (col_q == CW'(COLS));

endmodule

// File: rtl/rle_ctrl.sv
module rle_ctrl
  import rle_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16,
  parameter int SEL_W  = 6,
  parameter int FB_AW  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SEL_W-1:0]  frame_sel,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              tbl_rd_en,
  output logic [SEL_W-1:0]  tbl_rd_idx,
  input  logic [ADDR_W-1:0] tbl_offset,
  input  logic [LEN_W-1:0]  tbl_length,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              cur_clear,
  output logic              cur_step,
  input  logic [FB_AW-1:0]  cur_addr,
  input  logic              cur_past_end,
  output logic              fb_we,
  output logic [FB_AW-1:0]  fb_addr,
  output logic [7:0]        fb_wdata
);

  rle_state_e        state_q;
  logic [SEL_W-1:0]  sel_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [LEN_W-1:0]  rem_q;
  logic [7:0]        cnt_q;
  logic [7:0]        val_q;
  logic              first_q;
  logic              err_q;
  logic [7:0]        run_val;

  // read requests are decoded from registered state only
  always_comb begin
    tbl_rd_en   = (state_q == ST_DESC);
    tbl_rd_idx  = sel_q;
    mem_rd_en   = (state_q == ST_CREQ) || (state_q == ST_VREQ);
    mem_rd_addr = ptr_q;
    run_val     = first_q ? mem_rd_data : val_q;
    cur_clear   = (state_q == ST_DLAT);
    cur_step    = (state_q == ST_RUN) && !cur_past_end;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      sel_q    <= '0;
      ptr_q    <= '0;
      rem_q    <= '0;
      cnt_q    <= '0;
      val_q    <= '0;
      first_q  <= 1'b0;
      err_q    <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      error    <= 1'b0;
      fb_we    <= 1'b0;
      fb_addr  <= '0;
      fb_wdata <= '0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      fb_we <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            sel_q   <= frame_sel;
            err_q   <= 1'b0;
            busy    <= 1'b1;
            state_q <= ST_DESC;
          end
        end
        ST_DESC: state_q <= ST_DLAT;
        ST_DLAT: begin
          ptr_q <= tbl_offset;
          rem_q <= tbl_length;
          if (tbl_length[0]) begin
            err_q   <= 1'b1;
            state_q <= ST_FIN;
          end else if (tbl_length == '0) begin
            state_q <= ST_FIN;
          end else begin
            state_q <= ST_CREQ;
          end
        end
        ST_CREQ: begin
          ptr_q   <= ptr_q + ADDR_W'(1);
          state_q <= ST_VREQ;
        end
        ST_VREQ: begin
          ptr_q   <= ptr_q + ADDR_W'(1);
          rem_q   <= rem_q - LEN_W'(2);
          cnt_q   <= mem_rd_data;
          first_q <= 1'b1;
          if (mem_rd_data == 8'd0) begin
            err_q   <= 1'b1;
            state_q <= ST_FIN;
          end else begin
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          first_q <= 1'b0;
          if (first_q) val_q <= mem_rd_data;
          if (cur_past_end) begin
            err_q   <= 1'b1;
            state_q <= ST_FIN;
          end else begin
            fb_we    <= 1'b1;
            fb_addr  <= cur_addr;
            fb_wdata <= run_val;
            cnt_q    <= cnt_q - 8'd1;
            if (cnt_q == 8'd1) begin
              state_q <= (rem_q == '0) ? ST_FIN : ST_CREQ;
            end
          end
        end
        ST_FIN: begin
          done    <= 1'b1;
          error   <= err_q;
          busy    <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rle_frame_expander.sv
module rle_frame_expander #(
  parameter int IDX_W     = 8,
  parameter int FRAME_CNT = 50,
  parameter int ADDR_W    = 16,
  parameter int LEN_W     = 16,
  parameter int PAGES     = 8,
  parameter int COLS      = 128,
  localparam int FSEL_W   = (FRAME_CNT > 1) ? $clog2(FRAME_CNT) : 1,
  localparam int FB_AW    = $clog2(PAGES * COLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [IDX_W-1:0]  frame_idx,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              tbl_rd_en,
  output logic [FSEL_W-1:0] tbl_rd_idx,
  input  logic [ADDR_W-1:0] tbl_offset,
  input  logic [LEN_W-1:0]  tbl_length,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              fb_we,
  output logic [FB_AW-1:0]  fb_addr,
  output logic [7:0]        fb_wdata
);

  logic [FSEL_W-1:0] frame_sel;
  logic              cur_clear;
  logic              cur_step;
  logic [FB_AW-1:0]  cur_addr;
  logic              cur_past_end;

  rle_idx_wrap #(
    .IDX_W    (IDX_W),
    .FRAME_CNT(FRAME_CNT),
    .SEL_W    (FSEL_W)
  ) wrap_i (
    .idx(frame_idx),
    .sel(frame_sel)
  );

  rle_cursor #(
    .PAGES(PAGES),
    .COLS (COLS),
    .FB_AW(FB_AW)
  ) cursor_i (
    .clk     (clk),
    .rst     (rst),
    .clear   (cur_clear),
    .step    (cur_step),
    .addr    (cur_addr),
    .past_end(cur_past_end)
  );

  rle_ctrl #(
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W),
    .SEL_W (FSEL_W),
    .FB_AW (FB_AW)
  ) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .frame_sel   (frame_sel),
    .busy        (busy),
    .done        (done),
    .error       (error),
    .tbl_rd_en   (tbl_rd_en),
    .tbl_rd_idx  (tbl_rd_idx),
    .tbl_offset  (tbl_offset),
    .tbl_length  (tbl_length),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_data (mem_rd_data),
    .cur_clear   (cur_clear),
    .cur_step    (cur_step),
    .cur_addr    (cur_addr),
    .cur_past_end(cur_past_end),
    .fb_we       (fb_we),
    .fb_addr     (fb_addr),
    .fb_wdata    (fb_wdata)
  );

endmodule

// File: rtl/rle_frame_expander_chk.sv
module rle_frame_expander_chk #(
  parameter int PAGES = 8,
  parameter int COLS  = 128,
  parameter int FB_AW = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             done,
  input logic             error,
  input logic             tbl_rd_en,
  input logic             mem_rd_en,
  input logic             fb_we,
  input logic [FB_AW-1:0] fb_addr,
  input logic [7:0]       fb_wdata
);

  localparam int LAST_PAGE_BASE = (PAGES - 1) * COLS;

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && !fb_we);

  // R6
  error_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    error |-> done);

  // R2
  run_value_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fb_we && $past(fb_we)) |-> fb_wdata == $past(fb_wdata));

  // R3
  page_step_chk: assert property (@(posedge clk) disable iff (rst)
    (fb_we && $past(fb_we) && (int'($past(fb_addr)) < LAST_PAGE_BASE))
      |-> int'(fb_addr) == int'($past(fb_addr)) + COLS);

  // R3
  column_step_chk: assert property (@(posedge clk) disable iff (rst)
    (fb_we && $past(fb_we) && (int'($past(fb_addr)) >= LAST_PAGE_BASE))
      |-> int'(fb_addr) == int'($past(fb_addr)) - LAST_PAGE_BASE + 1);

  // R10
  write_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    fb_we |-> busy);

  // R10
  read_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (tbl_rd_en || mem_rd_en) |-> busy);

endmodule

bind rle_frame_expander rle_frame_expander_chk #(
  .PAGES(PAGES),
  .COLS (COLS),
  .FB_AW(FB_AW)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .error    (error),
  .tbl_rd_en(tbl_rd_en),
  .mem_rd_en(mem_rd_en),
  .fb_we    (fb_we),
  .fb_addr  (fb_addr),
  .fb_wdata (fb_wdata)
);

// File: tb/rle_frame_expander_tb_top.sv
`timescale 1ns/1ps
module rle_frame_expander_tb_top;

  localparam int IDX_W  = 4;
  localparam int NFR    = 6;
  localparam int ADDR_W = 12;
  localparam int LEN_W  = 12;
  localparam int SEL_W  = 3;
  localparam int FB_AW  = 10;
  localparam int MAXI   = 4096;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [IDX_W-1:0]  frame_idx = '0;
  logic              busy, done, error;
  logic              tbl_rd_en;
  logic [SEL_W-1:0]  tbl_rd_idx;
  logic [ADDR_W-1:0] tbl_offset = '0;
  logic [LEN_W-1:0]  tbl_length = '0;
  logic              mem_rd_en;
  logic [ADDR_W-1:0] mem_rd_addr;
  logic [7:0]        mem_rd_data = '0;
  logic              fb_we;
  logic [FB_AW-1:0]  fb_addr;
  logic [7:0]        fb_wdata;

  always #5 clk = ~clk;

  rle_frame_expander #(
    .IDX_W(IDX_W), .FRAME_CNT(NFR), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
    .PAGES(8), .COLS(128)
  ) dut_i (
    .clk(clk), .rst(rst), .start(start), .frame_idx(frame_idx),
    .busy(busy), .done(done), .error(error),
    .tbl_rd_en(tbl_rd_en), .tbl_rd_idx(tbl_rd_idx),
    .tbl_offset(tbl_offset), .tbl_length(tbl_length),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .fb_we(fb_we), .fb_addr(fb_addr), .fb_wdata(fb_wdata)
  );

  // storage model: one clock read latency
  logic [7:0] store [0:MAXI-1];
  int offs [0:NFR-1];
  int lens [0:NFR-1];
  int wptr = 0;

  always @(posedge clk) begin
    if (tbl_rd_en) begin
      tbl_offset <= ADDR_W'(offs[tbl_rd_idx]);
      tbl_length <= LEN_W'(lens[tbl_rd_idx]);
    end
    if (mem_rd_en) mem_rd_data <= store[mem_rd_addr];
  end

  int checks = 0;
  int errors = 0;

  // expected outputs per clock after the start edge
  int e_we [0:MAXI-1];
  int e_addr [0:MAXI-1];
  int e_data [0:MAXI-1];
  int e_done [0:MAXI-1];
  int e_err [0:MAXI-1];
  int e_busy [0:MAXI-1];
  int e_end;
  bit written [0:1023];
  int wr_count;

  task automatic add_rec(input int c, input int v);
    store[wptr]   = 8'(c);
    store[wptr+1] = 8'(v);
    wptr += 2;
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic build_model(input int f);
    int n, pos, rem, pg, cl, c, v;
    bit err, fin;
    for (int i = 0; i < MAXI; i++) begin
      e_we[i] = 0; e_addr[i] = 0; e_data[i] = 0;
      e_done[i] = 0; e_err[i] = 0; e_busy[i] = 0;
    end
    e_busy[1] = 1; e_busy[2] = 1;
    if ((lens[f] % 2) == 1 || lens[f] == 0) begin
      e_busy[3] = 1; e_done[4] = 1; e_err[4] = lens[f] % 2; e_end = 4;
      return;
    end
    pos = offs[f]; rem = lens[f]; pg = 0; cl = 0; n = 3; err = 0; fin = 0;
    while (!fin) begin
      e_busy[n] = 1; n++;
      e_busy[n] = 1;
      c = int'(store[pos]); v = int'(store[pos+1]); pos += 2; rem -= 2;
      n++;
      if (c == 0) begin
        err = 1;
      end else begin
        for (int k = 0; k < c && !err; k++) begin
          e_busy[n] = 1;
          if (cl == 128) begin
            err = 1;
          end else begin
            e_we[n+1] = 1; e_addr[n+1] = pg * 128 + cl; e_data[n+1] = v;
            pg++;
            if (pg == 8) begin pg = 0; cl++; end
          end
          n++;
        end
      end
      if (err || rem == 0) fin = 1;
    end
    e_busy[n] = 1; e_done[n+1] = 1; e_err[n+1] = err; e_end = n + 1;
  endtask

  task automatic run_frame(input int idx, input int f, input bit disturb,
                           input string tag);
    build_model(f);
    for (int a = 0; a < 1024; a++) written[a] = 0;
    wr_count = 0;
    @(negedge clk);
    start = 1'b1; frame_idx = IDX_W'(idx);
    for (int i = 1; i <= e_end; i++) begin
      @(negedge clk);
      if (i == 1) begin
        start = disturb;
        frame_idx = IDX_W'(3);
      end
      if (i == 3) start = 1'b0;
      if (fb_we) begin
        if (!written[fb_addr]) wr_count++;
        written[fb_addr] = 1;
      end
      if (fb_we !== 1'(e_we[i]) || (e_we[i] == 1 && int'(fb_addr) != e_addr[i]))
        check(0, {tag, "/R3"}, $sformatf("clk %0d fb_we/addr %0d/%0d", i, fb_we, fb_addr),
              e_we[i] * 2048 + int'(fb_addr), e_we[i] * 2048 + e_addr[i]);
      else if (e_we[i] == 1 && int'(fb_wdata) != e_data[i])
        check(0, {tag, "/R2"}, $sformatf("clk %0d fb_wdata", i), int'(fb_wdata), e_data[i]);
      else if (done !== 1'(e_done[i]))
        check(0, {tag, "/R8"}, $sformatf("clk %0d done", i), int'(done), e_done[i]);
      else if (error !== 1'(e_err[i]))
        check(0, {tag, "/R6"}, $sformatf("clk %0d error", i), int'(error), e_err[i]);
      else if (busy !== 1'(e_busy[i]))
        check(0, {tag, "/R9"}, $sformatf("clk %0d busy", i), int'(busy), e_busy[i]);
      else
        check(1, tag, "", 0, 0);
    end
    @(negedge clk);
    check(!busy && !done && !fb_we, {tag, "/R8"}, "idle after done", int'(busy), 0);
  endtask

  initial begin
    int total, j, c;
    // frame 0: long runs, exactly 1024 bytes
    offs[0] = wptr;
    add_rec(255, 8'hA5); add_rec(255, 8'h5A); add_rec(255, 8'h3C);
    add_rec(255, 8'hC3); add_rec(4, 8'hFF);
    lens[0] = wptr - offs[0];
    // frame 1: short mixed runs, exactly 1024 bytes
    offs[1] = wptr; total = 0; j = 0;
    while (total < 1024) begin
      c = (j % 9) + 1;
      if (c > 1024 - total) c = 1024 - total;
      add_rec(c, (j * 37 + 11) & 255);
      total += c; j++;
    end
    lens[1] = wptr - offs[1];
    // frame 2: odd length
    offs[2] = wptr; add_rec(3, 8'h10); add_rec(2, 8'h20); store[wptr] = 8'd1; wptr++;
    lens[2] = 5;
    // frame 3: zero count in second record
    offs[3] = wptr; add_rec(3, 8'h11); add_rec(0, 8'h22); add_rec(4, 8'h33);
    lens[3] = 6;
    // frame 4: runs overflow past column 127
    offs[4] = wptr;
    for (int r = 0; r < 4; r++) add_rec(255, 8'h40 + r);
    add_rec(10, 8'h77);
    lens[4] = wptr - offs[4];
    // frame 5: empty
    offs[5] = wptr; lens[5] = 0;

    repeat (3) @(negedge clk);
    // R10 reset state
    check(!busy && !done && !error && !fb_we && !tbl_rd_en && !mem_rd_en,
          "R10", "outputs during reset", int'(busy | done | fb_we), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !error && !fb_we && !tbl_rd_en && !mem_rd_en,
          "R10", "outputs after reset", int'(busy | done | fb_we), 0);

    run_frame(0, 0, 0, "R1_R5");       // long runs, timing and lookup
    check(wr_count == 1024, "R4", "distinct addresses frame 0", wr_count, 1024);
    run_frame(1, 1, 0, "R2_R5");       // many short runs
    check(wr_count == 1024, "R4", "distinct addresses frame 1", wr_count, 1024);
    run_frame(7, 1, 0, "R7");          // 7 mod 6 selects frame 1
    run_frame(12, 0, 0, "R7");         // 12 mod 6 selects frame 0
    run_frame(2, 2, 0, "R6_odd");
    run_frame(3, 3, 0, "R6_zero");
    run_frame(4, 4, 0, "R6_ovf");
    check(wr_count == 1024, "R6", "writes before overflow", wr_count, 1024);
    run_frame(5, 5, 0, "R11");
    check(wr_count == 0, "R11", "writes for empty frame", wr_count, 0);
    run_frame(0, 0, 1, "R9");          // start held high with another index mid-frame

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule